// File: doc/BRIEF.md
# Bus Request-Phase Capture and Address Parity Checker

This block listens to a shared processor system bus on which every signal is active low. It never drives the bus. When the address strobe is sampled asserted, it takes a snapshot of the address pins (bits 49 down to 3) and the six request pins. In the clock that follows, the same address pins carry further transaction detail, such as an identifier and external-function bits, and the block latches this as a second word. One clock after the strobe clock it presents the whole request as one record with a single-cycle valid pulse. All inputs are sampled on the rising clock edge and inverted to active-high before they are decoded.

Two address parity pins are checked against two ranges of unequal size, and each range has its own error flag. A parity pin is correct when it is electrically high for an even number of low covered pins, so a fully idle (all-high) range pairs with a high parity pin. The block decodes a memory-access qualifier from the request code and, for memory accesses only, the address-space size field. When reset is released, the block samples the address pins once and holds that value as the power-on configuration word.

Top module: `busReqCapture`

## Requirements
- R1: At a rising edge where `strobeN` is low and no request is in progress, `reqAddr` takes the inverted `addrN` and `reqCode` takes the inverted `reqN`. Both are presented with the valid pulse.
- R2: At the next rising edge, `reqExt` takes the inverted `addrN` as the second request word.
- R3: `reqValid` is high for exactly one clock. It becomes visible right after the edge that follows the strobe edge. Requests may be issued every second clock.
- R4: `parErr[1]` pulses with `reqValid` when `parN[1]` sampled at the strobe edge differs from its correct level. The correct level is high when the number of low pins in `addrN[49:27]` is even and low when it is odd.
- R5: `parErr[0]` follows the same rule for `parN[0]` over `addrN[26:3]`, independently of group 1.
- R6: With active-high request code q = ~`reqN`, `memAccess` = 1 when q[2:1] is 01, 10 or 11. `sizeValid` equals `memAccess`. `sizeCode` = q[4:3] when `sizeValid` is 1 and 00 otherwise.
- R7: A strobe sampled at the second-word edge does not start a request. The request in progress completes with `protoErr` = 1 in its valid cycle, and no extra `reqValid` follows.
- R8: While `rstN` is low, no request is captured: `reqValid`, `parErr`, `protoErr` and `cfgValid` stay 0, and a strobe during reset produces no valid pulse afterwards.
- R9: At the first rising edge where `rstN` is sampled high after being low, `cfgWord` takes the inverted `addrN` and `cfgValid` goes to 1. `cfgWord` then holds that value until the next reset, whatever the bus does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rstN | input | 1 | Bus reset, active low, sampled synchronously |
| strobeN | input | 1 | Address strobe, active low |
| addrN | input | 47 | Address pins [49:3], active low |
| reqN | input | 6 | Request code pins, active low |
| parN | input | 2 | Address parity pins: bit 1 covers [49:27], bit 0 covers [26:3] |
| reqValid | output | 1 | One-clock pulse: captured record is valid |
| reqAddr | output | 47 | Captured address, active high |
| reqCode | output | 6 | Captured request code, active high |
| reqExt | output | 47 | Second request word, active high |
| memAccess | output | 1 | Request is a memory access |
| sizeValid | output | 1 | `sizeCode` is meaningful |
| sizeCode | output | 2 | Address-space size field |
| parErr | output | 2 | Per-group parity error pulses |
| protoErr | output | 1 | Strobe seen during the second-word clock |
| cfgValid | output | 1 | Configuration word captured since reset release |
| cfgWord | output | 47 | Power-on configuration word, active high |

## Verification
The embedded assertions check, on every clock, that the valid pulse lasts one cycle, that the parity and protocol flags appear only inside a valid pulse, that no valid follows a clock spent in reset, that the configuration word does not change between resets, and that the control never stays in the second-word phase. The data itself can only be confirmed by the bench's scenarios: the captured address and request values, the second word, the parity decision for each group under odd and even counts of low pins, the size decode across all four qualifier values, the exact cycle of the pulse, and the value sampled at reset release.

// File: rtl/busReqPkg.sv
package busReqPkg;

  // Strobes from control to datapath, one per clock.
  typedef struct packed {
    logic capFirst;    // latch address, request code, parity result
    logic capSecond;   // latch second word and fire the record
    logic protoHit;    // strobe seen during second-word clock
    logic cfgCapture;  // first clock after reset release
  } busCtlT;

  typedef enum logic [0:0] {
    PH_IDLE   = 1'b0,
    PH_SECOND = 1'b1
  } phaseT;

endpackage

// File: rtl/busReqCtrl.sv
module busReqCtrl
  import busReqPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   strobeN,
  output busCtlT ctl
);

  phaseT phase;
  logic  rstSeen;
  logic  strobe;

  assign strobe = ~strobeN;

  always_comb begin
    ctl            = '0;
    ctl.capFirst   = rstN && (phase == PH_IDLE) && strobe;
    ctl.capSecond  = rstN && (phase == PH_SECOND);
    ctl.protoHit   = rstN && (phase == PH_SECOND) && strobe;
    ctl.cfgCapture = rstN && !rstSeen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      rstSeen <= 1'b0;
    end else begin
      rstSeen <= 1'b1;
      unique case (phase)
        PH_IDLE:   if (strobe) phase <= PH_SECOND;
        PH_SECOND: phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  AST_SECOND_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SECOND) |=> (phase == PH_IDLE)); // R7

  AST_CFG_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cfgCapture |=> !ctl.cfgCapture); // R9

endmodule

// File: rtl/busReqDatapath.sv
module busReqDatapath
  import busReqPkg::*;
#(
  parameter int ADDR_HI   = 49,
  parameter int ADDR_LO   = 3,
  parameter int PAR_SPLIT = 27,
  parameter int REQ_W     = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  busCtlT                 ctl,
  input  logic [ADDR_HI:ADDR_LO] addrN,
  input  logic [REQ_W-1:0]       reqN,
  input  logic [1:0]             parN,
  output logic                   reqValid,
  output logic [ADDR_HI:ADDR_LO] reqAddr,
  output logic [REQ_W-1:0]       reqCode,
  output logic [ADDR_HI:ADDR_LO] reqExt,
  output logic                   memAccess,
  output logic                   sizeValid,
  output logic [1:0]             sizeCode,
  output logic [1:0]             parErr,
  output logic                   protoErr,
  output logic                   cfgValid,
  output logic [ADDR_HI:ADDR_LO] cfgWord
);

  localparam int NUM_GRP = 2;
  localparam int QUAL_LO = 1;
  localparam int SIZE_LO = 3;

  logic [ADDR_HI:ADDR_LO] addrAct;
  logic [REQ_W-1:0]       reqAct;
  logic [NUM_GRP-1:0]     grpErr;
  logic [NUM_GRP-1:0]     errHold;
  logic                   isMem;

  assign addrAct = ~addrN;
  assign reqAct  = ~reqN;
  assign isMem   = |reqAct[QUAL_LO+1:QUAL_LO];

  // Correct pin level: high for an even count of low covered pins.
  for (genvar g = 0; g < NUM_GRP; g++) begin : gPar
    localparam int GHI = (g == 1) ? ADDR_HI : PAR_SPLIT - 1;
    localparam int GLO = (g == 1) ? PAR_SPLIT : ADDR_LO;
    logic pinOk;
    assign pinOk     = ~(^addrAct[GHI:GLO]);
    assign grpErr[g] = parN[g] ^ pinOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr   <= '0;
      reqCode   <= '0;
      reqExt    <= '0;
      memAccess <= 1'b0;
      sizeValid <= 1'b0;
      sizeCode  <= '0;
      errHold   <= '0;
    end else begin
      if (ctl.capFirst) begin
        reqAddr   <= addrAct;
        reqCode   <= reqAct;
        memAccess <= isMem;
        sizeValid <= isMem;
        sizeCode  <= isMem ? reqAct[SIZE_LO+1:SIZE_LO] : 2'b00;
        errHold   <= grpErr;
      end
      if (ctl.capSecond) begin
        reqExt <= addrAct;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqValid <= 1'b0;
      parErr   <= '0;
      protoErr <= 1'b0;
    end else begin
      reqValid <= ctl.capSecond;
      parErr   <= ctl.capSecond ? errHold : '0;
      protoErr <= ctl.protoHit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgValid <= 1'b0;
      cfgWord  <= '0;
    end else if (ctl.cfgCapture) begin
      cfgValid <= 1'b1;
      cfgWord  <= addrAct;
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid); // R3

  AST_PARERR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (|parErr) |-> reqValid); // R4

  AST_PROTO_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> reqValid); // R7

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $past(rstN)); // R8

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> $stable(cfgWord)); // R9

  AST_SIZE_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    (sizeCode != 2'b00) |-> (sizeValid && memAccess)); // R6

endmodule

// File: rtl/busReqCapture.sv
module busReqCapture
  import busReqPkg::*;
#(
  parameter int ADDR_HI   = 49,
  parameter int ADDR_LO   = 3,
  parameter int PAR_SPLIT = 27,
  parameter int REQ_W     = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   strobeN,
  input  logic [ADDR_HI:ADDR_LO] addrN,
  input  logic [REQ_W-1:0]       reqN,
  input  logic [1:0]             parN,
  output logic                   reqValid,
  output logic [ADDR_HI:ADDR_LO] reqAddr,
  output logic [REQ_W-1:0]       reqCode,
  output logic [ADDR_HI:ADDR_LO] reqExt,
  output logic                   memAccess,
  output logic                   sizeValid,
  output logic [1:0]             sizeCode,
  output logic [1:0]             parErr,
  output logic                   protoErr,
  output logic                   cfgValid,
  output logic [ADDR_HI:ADDR_LO] cfgWord
);

  busCtlT ctl;

  busReqCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobeN (strobeN),
    .ctl     (ctl)
  );

  busReqDatapath #(
    .ADDR_HI   (ADDR_HI),
    .ADDR_LO   (ADDR_LO),
    .PAR_SPLIT (PAR_SPLIT),
    .REQ_W     (REQ_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .addrN     (addrN),
    .reqN      (reqN),
    .parN      (parN),
    .reqValid  (reqValid),
    .reqAddr   (reqAddr),
    .reqCode   (reqCode),
    .reqExt    (reqExt),
    .memAccess (memAccess),
    .sizeValid (sizeValid),
    .sizeCode  (sizeCode),
    .parErr    (parErr),
    .protoErr  (protoErr),
    .cfgValid  (cfgValid),
    .cfgWord   (cfgWord)
  );

endmodule

// File: tb/busReqCapture_tb.sv
module busReqCapture_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        strobeN;
  logic [49:3] addrN;
  logic [5:0]  reqN;
  logic [1:0]  parN;
  logic        reqValid;
  logic [49:3] reqAddr;
  logic [5:0]  reqCode;
  logic [49:3] reqExt;
  logic        memAccess;
  logic        sizeValid;
  logic [1:0]  sizeCode;
  logic [1:0]  parErr;
  logic        protoErr;
  logic        cfgValid;
  logic [49:3] cfgWord;

  always #5 clk = ~clk;

  busReqCapture u_dut (
    .clk(clk), .rstN(rstN), .strobeN(strobeN), .addrN(addrN), .reqN(reqN),
    .parN(parN), .reqValid(reqValid), .reqAddr(reqAddr), .reqCode(reqCode),
    .reqExt(reqExt), .memAccess(memAccess), .sizeValid(sizeValid),
    .sizeCode(sizeCode), .parErr(parErr), .protoErr(protoErr),
    .cfgValid(cfgValid), .cfgWord(cfgWord)
  );

  typedef struct {
    logic [49:3] addr;
    logic [5:0]  code;
    logic [49:3] ext;
    logic [1:0]  perr;
    logic        proto;
    logic        mem;
    logic [1:0]  size;
    int          due;
  } expT;

  expT expQ[$];
  int  nChecks = 0;
  int  nFails  = 0;
  int  cyc     = 0;
  bit  done    = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // Correct pin level: high for an even count of low pins in the range.
  function automatic logic parPin(input logic [49:3] a, input int hi, input int lo);
    int lows = 0;
    for (int i = lo; i <= hi; i++) if (a[i]) lows++;
    return (lows % 2) == 0;
  endfunction

  task automatic sendReq(input logic [49:3] a, input logic [5:0] q,
                         input logic [49:3] e, input logic [1:0] flip,
                         input bit dbl);
    expT it;
    it.addr  = a;
    it.code  = q;
    it.ext   = e;
    it.perr  = flip;
    it.proto = dbl;
    it.mem   = (q[2:1] != 2'b00);
    it.size  = it.mem ? q[4:3] : 2'b00;
    it.due   = cyc + 2;
    expQ.push_back(it);
    strobeN  = 1'b0;
    addrN    = ~a;
    reqN     = ~q;
    parN[1]  = parPin(a, 49, 27) ^ flip[1];
    parN[0]  = parPin(a, 26, 3)  ^ flip[0];
    @(negedge clk);
    strobeN  = dbl ? 1'b0 : 1'b1;
    addrN    = ~e;
    reqN     = $urandom();
    parN     = $urandom();
    @(negedge clk);
    strobeN  = 1'b1;
    addrN    = '1;
    reqN     = '1;
    parN     = '1;
  endtask

  // Monitor: pops the scoreboard whenever a record appears.
  always @(negedge clk) begin
    if (rstN === 1'b1 && !done) begin
      if (reqValid === 1'b1) begin
        if (expQ.size() == 0) begin
          chk("R7", "unexpected valid", 64'd1, 64'd0);
        end else begin
          expT it;
          it = expQ.pop_front();
          chk("R3", "valid cycle", 64'(cyc), 64'(it.due));
          chk("R1", "address", 64'(reqAddr), 64'(it.addr));
          chk("R1", "request code", 64'(reqCode), 64'(it.code));
          chk("R2", "second word", 64'(reqExt), 64'(it.ext));
          chk("R4", "group1 parity", 64'(parErr[1]), 64'(it.perr[1]));
          chk("R5", "group0 parity", 64'(parErr[0]), 64'(it.perr[0]));
          chk("R6", "memAccess", 64'(memAccess), 64'(it.mem));
          chk("R6", "sizeValid", 64'(sizeValid), 64'(it.mem));
          chk("R6", "sizeCode", 64'(sizeCode), 64'(it.size));
          chk("R7", "protoErr", 64'(protoErr), 64'(it.proto));
        end
      end else if (reqValid !== 1'b0 || parErr !== 2'b00 || protoErr !== 1'b0) begin
        chk("R3", "flags outside valid", {61'd0, reqValid, parErr}, 64'd0);
      end
    end
  end

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  task automatic resetPhase(input logic [49:3] cfg);
    rstN    = 1'b0;
    strobeN = 1'b1;
    addrN   = '1;
    reqN    = '1;
    parN    = '1;
    repeat (3) @(negedge clk);
    chk("R8", "reqValid in reset", 64'(reqValid), 64'd0);
    chk("R8", "cfgValid in reset", 64'(cfgValid), 64'd0);
    chk("R8", "parErr in reset", 64'(parErr), 64'd0);
    // strobe while reset is held
    strobeN = 1'b0;
    addrN   = ~47'h1234;
    reqN    = 6'b000000;
    parN    = 2'b00;
    @(negedge clk);
    strobeN = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8", "no valid from reset strobe", 64'({reqValid, protoErr}), 64'd0);
    end
    addrN = ~cfg;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    addrN = '1;
    chk("R8", "no valid after release", 64'(reqValid), 64'd0);
    chk("R9", "cfgValid", 64'(cfgValid), 64'd1);
    chk("R9", "cfgWord", 64'(cfgWord), 64'(cfg));
  endtask

  initial begin
    logic [49:3] cfgA;
    cfgA = 47'h5A5A_1234_0F0F;
    resetPhase(cfgA);

    // all pins idle-high equivalent: address all-zero active high
    sendReq('0, 6'b000010, '0, 2'b00, 0);
    // all address pins low
    sendReq('1, 6'b011110, 47'h7FFF_0000_0001, 2'b00, 0);
    // parity flips per group
    sendReq(47'h0000_0000_0001, 6'b001100, 47'h3, 2'b10, 0);
    sendReq(47'h4000_0000_0000, 6'b010010, 47'h5, 2'b01, 0);
    sendReq(47'h1234_5678_9ABC, 6'b111011, 47'h77, 2'b11, 0);
    // size decode over all qualifier values
    for (int qv = 0; qv < 4; qv++) begin
      for (int sz = 0; sz < 4; sz++) begin
        logic [5:0] q;
        q = {1'b1, 2'(sz), 2'(qv), 1'b0};
        sendReq({$urandom(), $urandom()}, q, {$urandom(), $urandom()}, 2'b00, 0);
      end
    end
    // strobe during second-word clock
    sendReq(47'h0ABC_DEF0_1234, 6'b000110, 47'h1111, 2'b00, 1);
    sendReq(47'h0000_0FFF_F000, 6'b001010, 47'h2222, 2'b01, 0);
    // random back-to-back traffic
    for (int n = 0; n < 40; n++) begin
      sendReq({$urandom(), $urandom()}, 6'($urandom()), {$urandom(), $urandom()},
              2'($urandom()), bit'($urandom() % 5 == 0));
    end
    repeat (4) @(negedge clk);
    chk("R3", "scoreboard drained", 64'(expQ.size()), 64'd0);
    chk("R9", "cfgWord held across traffic", 64'(cfgWord), 64'(cfgA));

    // second reset recaptures configuration
    resetPhase(47'h0123_4567_89AB);
    sendReq(47'h7654_3210_FEDC, 6'b101010, 47'h9999, 2'b10, 0);
    repeat (4) @(negedge clk);
    chk("R3", "scoreboard drained after reset", 64'(expQ.size()), 64'd0);
    finish();
  end

endmodule